// File: doc/BRIEF.md
# Single-Channel Byte Mover with Circular Reload

This block is one channel of a byte mover that copies data between a memory buffer and a peripheral data register. Each byte moves only when the peripheral raises its request line. Software sets up the channel through a small register port. It writes a base address for each side, a byte count, and a control word that picks the direction, the address-stepping rules, the looping behaviour and the interrupt enables. Each byte takes one read beat on a single-beat master port, then one write beat.

The remaining-count register decides whether the channel may move data. In one-shot mode the channel stops when the count reaches zero, even if it is still enabled, and software must disable it and write a new count before the next run. In looping mode the count refills itself from the last programmed value, both address pointers return to their bases, and bytes keep flowing until software clears the enable bit. Completion and half-way flags are cleared by writing 1. They drive a level interrupt through their enable bits.

Top module: `dma_ring_chan`

## Requirements
- R1: After reset the control word, count, flags, interrupt and master request all read 0.
- R2: Each byte moves as a read beat at the source pointer, then a write beat of the same byte at the destination pointer. With control bit 4 (to-peripheral) set, the source is the memory pointer and the destination is the peripheral pointer. With bit 4 clear, the roles are reversed.
- R3: A transfer starts only while periph_req is high. With periph_req low and no transfer in flight, the master port stays idle.
- R4: In one-shot mode (control bit 1 clear), once the count (offset 1) reaches 0 no further transfer starts, even with the enable bit (control bit 0) still set.
- R5: A write to the count register is ignored while the enable bit is set. Reading it back shows the unchanged count.
- R6: In looping mode (control bit 1 set), the transfer that takes the count to 0 reloads the count to the programmed value and returns both pointers to their bases. Transfers then continue.
- R7: The memory pointer steps by 1 per byte when control bit 2 is set, and the peripheral pointer steps by 1 per byte when control bit 3 is set. A pointer whose bit is clear stays fixed.
- R8: Status (offset 4) bit 2 (half) sets when the count falls to floor(programmed/2), and bit 1 (complete) sets when it falls to 0. Bit 0 reads as the OR of bits 1 and 2.
- R9: Writing 1 to bit 1 or bit 2 of the clear register (offset 5) clears that flag, and writing 1 to bit 0 clears both flags. A 0 bit leaves its flag alone.
- R10: irq is high exactly when (complete and control bit 5) or (half and control bit 6).
- R11: Clearing the enable bit lets a transfer already in flight finish, then stops the channel and keeps the remaining count. Setting the enable bit copies both base addresses (offsets 2 and 3) into the pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| periph_req | input | 1 | Peripheral asks for one byte |
| m_req | output | 1 | Master beat valid |
| m_we | output | 1 | Beat is a write (1) or read (0) |
| m_addr | output | ADDR_W | Beat address |
| m_wdata | output | 8 | Write byte |
| m_rdata | input | 8 | Read byte, valid with m_ack |
| m_ack | input | 1 | Beat accepted this cycle |
| irq | output | 1 | Interrupt level |

## Verification
The bench builds the channel with ADDR_W = 16 and CNT_W = 8, and uses counts of 3 to 7. With counts this small, several loop wraps, the half-way threshold (count 7 gives 3) and the return to zero all fit in a few hundred cycles. The 16-bit addresses let the bench model memory as a simple function of the address, so it can predict every moved byte in both directions.

// File: rtl/dma_chan_pkg.sv
// Shared offsets and types for the byte-mover channel.
// Assumes a 3-bit register offset and a 32-bit register data path.
package dma_chan_pkg;
    localparam logic [2:0] OFS_CTRL  = 3'd0;
    localparam logic [2:0] OFS_COUNT = 3'd1;
    localparam logic [2:0] OFS_PADDR = 3'd2;
    localparam logic [2:0] OFS_MADDR = 3'd3;
    localparam logic [2:0] OFS_STAT  = 3'd4;
    localparam logic [2:0] OFS_CLR   = 3'd5;

    localparam int CTRL_W = 7;

    // Control word, en at bit 0 up to ht_ie at bit 6.
    typedef struct packed {
        logic ht_ie;
        logic tc_ie;
        logic to_periph;
        logic pinc;
        logic minc;
        logic circ;
        logic en;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } xfer_st_e;
endpackage

// File: rtl/dma_chan_regs.sv
// Register file: control word, count with reload, base addresses, readback.
// Assumes ADDR_W and CNT_W are at most 32. The count refills on wrap in looping mode.
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              xfer_done,
    input  logic [2:0]        flags,
    output ctrl_t             ctrl_q,
    output logic              en_set,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [CNT_W-1:0]  reload_q,
    output logic [ADDR_W-1:0] pbase_q,
    output logic [ADDR_W-1:0] mbase_q,
    output logic [2:0]        clr_mask,
    output logic [31:0]       reg_rdata
);
    logic wr_ctrl, wr_cnt;

    assign wr_ctrl  = reg_wr && (reg_addr == OFS_CTRL);
    assign wr_cnt   = reg_wr && (reg_addr == OFS_COUNT) && !ctrl_q.en;
    assign en_set   = wr_ctrl && reg_wdata[0] && !ctrl_q.en;
    assign clr_mask = (reg_wr && reg_addr == OFS_CLR) ? reg_wdata[2:0] : 3'b000;

    // Control word and base addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            pbase_q <= '0;
            mbase_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
            if (reg_wr && reg_addr == OFS_PADDR) pbase_q <= reg_wdata[ADDR_W-1:0];
            if (reg_wr && reg_addr == OFS_MADDR) mbase_q <= reg_wdata[ADDR_W-1:0];
        end
    end

    // Remaining count: written only while disabled, decremented per byte, refilled on loop wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            reload_q <= '0;
        end else if (wr_cnt) begin
            cnt_q    <= reg_wdata[CNT_W-1:0];
            reload_q <= reg_wdata[CNT_W-1:0];
        end else if (xfer_done) begin
            if (ctrl_q.circ && cnt_q == CNT_W'(1)) cnt_q <= reload_q;
            else                                   cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Readback multiplexer.
    always_comb begin
        case (reg_addr)
            OFS_CTRL:  reg_rdata = 32'(ctrl_q);
            OFS_COUNT: reg_rdata = 32'(cnt_q);
            OFS_PADDR: reg_rdata = 32'(pbase_q);
            OFS_MADDR: reg_rdata = 32'(mbase_q);
            OFS_STAT:  reg_rdata = 32'(flags);
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma_chan_engine.sv
// Transfer engine: one read beat then one write beat per request. It also owns the pointers.
// Assumes the count is nonzero before a transfer starts. A transfer in flight always completes.
module dma_chan_engine
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_t             ctrl_q,
    input  logic              en_set,
    input  logic [ADDR_W-1:0] pbase_q,
    input  logic [ADDR_W-1:0] mbase_q,
    input  logic              cnt_nonzero,
    input  logic              wrap,
    input  logic              periph_req,
    input  logic              m_ack,
    input  logic [7:0]        m_rdata,
    output logic              m_req,
    output logic              m_we,
    output logic [ADDR_W-1:0] m_addr,
    output logic [7:0]        m_wdata,
    output logic              xfer_done
);
    xfer_st_e          st_q;
    logic [ADDR_W-1:0] pptr_q, mptr_q, src, dst;
    logic [7:0]        buf_q;

    assign src       = ctrl_q.to_periph ? mptr_q : pptr_q;
    assign dst       = ctrl_q.to_periph ? pptr_q : mptr_q;
    assign m_req     = (st_q != ST_IDLE);
    assign m_we      = (st_q == ST_WRITE);
    assign m_addr    = (st_q == ST_WRITE) ? dst : src;
    assign m_wdata   = buf_q;
    assign xfer_done = (st_q == ST_WRITE) && m_ack;

    // Beat sequencing and read-data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            buf_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE:  if (ctrl_q.en && cnt_nonzero && periph_req) st_q <= ST_READ;
                ST_READ:  if (m_ack) begin
                              buf_q <= m_rdata;
                              st_q  <= ST_WRITE;
                          end
                ST_WRITE: if (m_ack) st_q <= ST_IDLE;
                default:  st_q <= ST_IDLE;
            endcase
        end
    end

    // Pointers: loaded on enable or wrap, stepped per completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pptr_q <= '0;
            mptr_q <= '0;
        end else if (en_set || (xfer_done && wrap)) begin
            pptr_q <= pbase_q;
            mptr_q <= mbase_q;
        end else if (xfer_done) begin
            pptr_q <= pptr_q + ADDR_W'(ctrl_q.pinc);
            mptr_q <= mptr_q + ADDR_W'(ctrl_q.minc);
        end
    end
endmodule

// File: rtl/dma_chan_flags.sv
// Half-way and complete flags with write-1-to-clear, plus the interrupt level.
// Assumes a flag being set wins over a clear in the same cycle.
module dma_chan_flags #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_done,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] reload_q,
    input  logic [2:0]       clr_mask,
    input  logic             tc_ie,
    input  logic             ht_ie,
    output logic [2:0]       flags,
    output logic             irq
);
    logic tc_q, ht_q, hit_tc, hit_ht;

    assign hit_tc = xfer_done && (cnt_q == CNT_W'(1));
    assign hit_ht = xfer_done && ((cnt_q - CNT_W'(1)) == (reload_q >> 1));
    assign flags  = {ht_q, tc_q, tc_q | ht_q};
    assign irq    = (tc_q && tc_ie) || (ht_q && ht_ie);

    // Flag set on threshold, cleared by writing 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_q <= 1'b0;
            ht_q <= 1'b0;
        end else begin
            if (hit_tc)                          tc_q <= 1'b1;
            else if (clr_mask[1] || clr_mask[0]) tc_q <= 1'b0;
            if (hit_ht)                          ht_q <= 1'b1;
            else if (clr_mask[2] || clr_mask[0]) ht_q <= 1'b0;
        end
    end
endmodule

// File: rtl/dma_ring_chan.sv
// Top level of the single-channel byte mover with one-shot and looping modes.
// Assumes a single-beat master whose m_ack completes the current beat.
module dma_ring_chan
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              periph_req,
    output logic              m_req,
    output logic              m_we,
    output logic [ADDR_W-1:0] m_addr,
    output logic [7:0]        m_wdata,
    input  logic [7:0]        m_rdata,
    input  logic              m_ack,
    output logic              irq
);
    ctrl_t             ctrl_q;
    logic              en_set, xfer_done, chan_en, tc_flag;
    logic [CNT_W-1:0]  cnt_q, reload_q;
    logic [ADDR_W-1:0] pbase_q, mbase_q;
    logic [2:0]        clr_mask, flags;

    assign chan_en = ctrl_q.en;
    assign tc_flag = flags[1];

    dma_chan_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .xfer_done(xfer_done), .flags(flags),
        .ctrl_q(ctrl_q), .en_set(en_set), .cnt_q(cnt_q), .reload_q(reload_q),
        .pbase_q(pbase_q), .mbase_q(mbase_q), .clr_mask(clr_mask),
        .reg_rdata(reg_rdata)
    );

    dma_chan_engine #(.ADDR_W(ADDR_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .en_set(en_set),
        .pbase_q(pbase_q), .mbase_q(mbase_q),
        .cnt_nonzero(cnt_q != '0),
        .wrap(ctrl_q.circ && cnt_q == CNT_W'(1)),
        .periph_req(periph_req), .m_ack(m_ack), .m_rdata(m_rdata),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
        .xfer_done(xfer_done)
    );

    dma_chan_flags #(.CNT_W(CNT_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .xfer_done(xfer_done), .cnt_q(cnt_q),
        .reload_q(reload_q), .clr_mask(clr_mask), .tc_ie(ctrl_q.tc_ie),
        .ht_ie(ctrl_q.ht_ie), .flags(flags), .irq(irq)
    );
endmodule

// File: rtl/dma_ring_chan_chk.sv
// Protocol and state checks for the byte-mover channel, bound to the top level.
module dma_ring_chan_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             periph_req,
    input logic             m_req,
    input logic             m_we,
    input logic             m_ack,
    input logic             chan_en,
    input logic             xfer_done,
    input logic             tc_flag,
    input logic [CNT_W-1:0] cnt_q,
    input logic             reg_wr,
    input logic [2:0]       reg_addr,
    input logic [31:0]      reg_wdata
);
    // R3
    req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!periph_req && !m_req) |=> !m_req);

    // R2
    rd_before_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_we && !$past(m_req && m_we)) |-> $past(m_req && !m_we && m_ack));

    // R4
    empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !m_req) |=> !m_req);

    // R5
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && !xfer_done) |=> (cnt_q == $past(cnt_q)));

    // R8
    tc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && cnt_q == CNT_W'(1)) |=> tc_flag);

    // R9
    tc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd5 && reg_wdata[1] && !(xfer_done && cnt_q == CNT_W'(1)))
        |=> !tc_flag);
endmodule

bind dma_ring_chan dma_ring_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .periph_req(periph_req), .m_req(m_req),
    .m_we(m_we), .m_ack(m_ack), .chan_en(chan_en), .xfer_done(xfer_done),
    .tc_flag(tc_flag), .cnt_q(cnt_q), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata)
);

// File: tb/dma_ring_chan_tb.sv
// Directed bench for the byte-mover channel: one task per scenario.
module dma_ring_chan_tb;
    localparam int ADDR_W = 16;
    localparam int CNT_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [2:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              periph_req = 1'b0;
    logic              m_req, m_we, irq;
    logic [ADDR_W-1:0] m_addr;
    logic [7:0]        m_wdata, m_rdata;
    logic              m_ack = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;
    int wr_n     = 0;
    logic [ADDR_W-1:0] wr_addr [0:511];
    logic [7:0]        wr_data [0:511];

    always #2.5 clk = ~clk;

    function automatic logic [7:0] mem_model(input logic [ADDR_W-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    assign m_rdata = mem_model(m_addr);

    dma_ring_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_req(periph_req),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_rdata(m_rdata), .m_ack(m_ack), .irq(irq)
    );

    // Log every accepted write beat.
    always @(posedge clk) begin
        if (rst_n && m_req && m_we && m_ack && wr_n < 512) begin
            wr_addr[wr_n] <= m_addr;
            wr_data[wr_n] <= m_wdata;
            wr_n <= wr_n + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One request pulse held until exactly one byte has been written.
    task automatic one_xfer();
        int start = wr_n;
        periph_req = 1'b1;
        for (int i = 0; i < 50 && wr_n == start; i++) @(negedge clk);
        periph_req = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        reg_read(3'd0, d); chk("R1 ctrl", d, 0);
        reg_read(3'd1, d); chk("R1 count", d, 0);
        reg_read(3'd4, d); chk("R1 status", d, 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 m_req", 32'(m_req), 0);
    endtask

    task automatic t_oneshot();
        logic [31:0] d;
        int base = wr_n;
        reg_write(3'd2, 32'h4000);
        reg_write(3'd3, 32'h1000);
        reg_write(3'd1, 6);
        reg_write(3'd0, 32'h35);   // en, minc, to_periph, tc_ie
        periph_req = 1'b1;
        idle(40);
        chk("R4 count of bytes", 32'(wr_n - base), 6);
        for (int i = 0; i < 6; i++) begin
            chk("R7 fixed periph addr", 32'(wr_addr[base+i]), 32'h4000);
            chk("R2 mem to periph data", 32'(wr_data[base+i]), 32'(mem_model(16'(16'h1000 + i))));
        end
        reg_read(3'd1, d); chk("R4 count zero", d, 0);
        idle(20);
        chk("R4 stays stopped while enabled", 32'(wr_n - base), 6);
        reg_read(3'd4, d); chk("R8 all flags", d, 32'h7);
        chk("R10 irq via complete", 32'(irq), 1);
        reg_write(3'd1, 5);
        reg_read(3'd1, d); chk("R5 write ignored", d, 0);
        idle(10);
        chk("R5 no new bytes", 32'(wr_n - base), 6);
        reg_write(3'd5, 32'h2);
        reg_read(3'd4, d); chk("R9 clear complete only", d, 32'h5);
        chk("R10 irq drops, half not enabled", 32'(irq), 0);
        reg_write(3'd5, 32'h4);
        reg_read(3'd4, d); chk("R8 global follows", d, 0);
        periph_req = 1'b0;
        // Re-arm: disable, new count, enable reloads pointers from base.
        reg_write(3'd0, 32'h34);
        reg_write(3'd1, 3);
        reg_read(3'd1, d); chk("R5 write accepted when disabled", d, 3);
        base = wr_n;
        reg_write(3'd0, 32'h35);
        periph_req = 1'b1;
        idle(30);
        periph_req = 1'b0;
        chk("R11 rearmed byte count", 32'(wr_n - base), 3);
        chk("R11 restart at memory base", 32'(wr_data[base]), 32'(mem_model(16'h1000)));
        chk("R7 step on restart", 32'(wr_data[base+2]), 32'(mem_model(16'h1002)));
        reg_write(3'd0, 32'h0);
        reg_write(3'd5, 32'h1);
    endtask

    task automatic t_half();
        logic [31:0] d;
        int base;
        reg_write(3'd2, 32'h4100);
        reg_write(3'd3, 32'h1200);
        reg_write(3'd1, 7);
        reg_write(3'd0, 32'h55);   // en, minc, to_periph, ht_ie
        base = wr_n;
        for (int k = 0; k < 3; k++) one_xfer();
        idle(3);
        chk("R3 one byte per request", 32'(wr_n - base), 3);
        reg_read(3'd4, d); chk("R8 half not yet at 4 left", d, 0);
        chk("R10 irq low", 32'(irq), 0);
        idle(20);
        chk("R3 no request no byte", 32'(wr_n - base), 3);
        one_xfer();
        idle(3);
        reg_read(3'd4, d); chk("R8 half set at 3 left", d, 32'h5);
        chk("R10 irq via half", 32'(irq), 1);
        periph_req = 1'b1;
        idle(20);
        periph_req = 1'b0;
        chk("R4 seven bytes", 32'(wr_n - base), 7);
        reg_read(3'd4, d); chk("R8 complete joins", d, 32'h7);
        reg_write(3'd5, 32'h1);
        reg_read(3'd4, d); chk("R9 clear all", d, 0);
        chk("R10 irq cleared", 32'(irq), 0);
        reg_write(3'd0, 32'h0);
    endtask

    task automatic t_circular();
        logic [31:0] d;
        int base, n, exp_cnt;
        reg_write(3'd2, 32'h4200);
        reg_write(3'd3, 32'h2000);
        reg_write(3'd1, 4);
        base = wr_n;
        reg_write(3'd0, 32'h17);   // en, circ, minc, to_periph
        periph_req = 1'b1;
        idle(45);
        reg_write(3'd0, 32'h16);   // disable
        periph_req = 1'b0;
        idle(8);
        n = wr_n - base;
        chk("R6 streams past count", 32'(n > 4), 1);
        for (int i = 0; i < n; i++)
            chk("R6 wrap to base", 32'(wr_data[base+i]), 32'(mem_model(16'(16'h2000 + (i % 4)))));
        exp_cnt = (n % 4 == 0) ? 4 : 4 - (n % 4);
        reg_read(3'd1, d); chk("R11 count kept", d, 32'(exp_cnt));
        periph_req = 1'b1;
        idle(20);
        chk("R11 stopped after disable", 32'(wr_n - base), 32'(n));
        base = wr_n;
        reg_write(3'd0, 32'h17);
        idle(6);
        reg_write(3'd0, 32'h16);
        periph_req = 1'b0;
        idle(6);
        chk("R11 enable resumes", 32'(wr_n > base), 1);
        chk("R11 pointers from base", 32'(wr_data[base]), 32'(mem_model(16'h2000)));
        reg_write(3'd5, 32'h1);
    endtask

    task automatic t_inbound();
        int base;
        reg_write(3'd2, 32'h3000);
        reg_write(3'd3, 32'h5000);
        reg_write(3'd1, 3);
        base = wr_n;
        reg_write(3'd0, 32'h0D);   // en, minc, pinc, to memory
        periph_req = 1'b1;
        idle(30);
        periph_req = 1'b0;
        chk("R2 inbound byte count", 32'(wr_n - base), 3);
        for (int i = 0; i < 3; i++) begin
            chk("R7 memory dest steps", 32'(wr_addr[base+i]), 32'(16'h5000 + i));
            chk("R2 periph source data", 32'(wr_data[base+i]), 32'(mem_model(16'(16'h3000 + i))));
        end
        reg_write(3'd0, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_oneshot();
        t_half();
        t_circular();
        t_inbound();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule